// File: doc/BRIEF.md
# Polar Decoder Low-Stage LLR Memory Controller

This block holds the internal log-likelihood ratios of a semi-parallel successive-cancellation polar decoder with PE processing lanes. Storage is organised in words of PE values, each Q bits wide. The processing datapath talks to it with a stage number and a word offset. Stages whose vectors fill at least one whole word get words of their own. Every stage whose vector is shorter than a word is folded into a single shared word.

That shared word is kept in two copies. One copy is read while the other takes the merged update. A selector flips after each update. This keeps the one-cycle read-while-write step of the decoder intact. Without the copies, every small stage would need its own mostly empty word. The total storage is PE·Q·(N/PE + 1) bits.

A read request is answered one cycle later. A write takes effect at the same clock edge. A read that meets a write to the same word in the same cycle returns the contents from before the write.

Top module: `llr_lowstage_mem`

## Requirements
- R1: After reset, rd_valid and rd_data are zero, and every valid stage/offset reads back as all-zero LLRs.
- R2: rd_valid is high in the cycle after a cycle with rd_en high, and low in the cycle after a cycle with rd_en low. rd_data is registered with the same one-cycle latency.
- R3: For a stage s with log2(PE) <= s < log2(N), offset o addresses the word that holds LLRs o·PE .. o·PE+PE-1 of that stage, for o < 2^s/PE. Lane i sits at bits i·Q. A write followed by a read returns the written word, and words of other stages or offsets are unchanged.
- R4: For a stage s < log2(PE), the offset is ignored. A write stores lanes 0 .. 2^s-1 of wr_data as the stage's 2^s LLRs, which sit at lanes 2^s-1 .. 2^(s+1)-2 of the shared word. A read returns those LLRs in lanes 0 .. 2^s-1 and zero in all higher lanes.
- R5: A write to one small stage leaves the stored LLRs of every other small stage unchanged.
- R6: A read in the same cycle as a write to the same word, large or shared, returns the contents from before the write. The new data is visible to a read in the next cycle.
- R7: A write to a stage >= log2(N), or to a large stage with o >= 2^s/PE, changes no stored value. A read of such an address returns all zeros.
- R8: Each write to a small stage switches the active copy of the shared word, and no other access switches it. Back-to-back small-stage writes in consecutive cycles therefore all persist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_stage | input | STAGE_W | Stage of the read |
| rd_ofs | input | OFS_W | Word offset within the read stage |
| wr_en | input | 1 | Write request |
| wr_stage | input | STAGE_W | Stage of the write |
| wr_ofs | input | OFS_W | Word offset within the write stage |
| wr_data | input | PE*Q | Write data, lane i at bits i*Q |
| rd_data | output | PE*Q | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rd_data carries the answer to last cycle's read |

## Verification
A read and a write can land in the same cycle. The interesting case is when both target the same large word or the shared small-stage word. The bench forces this case with directed steps, and also steers about a third of its random cycles to reuse the write address for the read. The per-cycle reference model computes the expected read data from its state before the write is applied. A correct design must therefore return the old values, and the new values must appear on the following read. Back-to-back writes to different small stages, each followed by reads, show whether the copy swap loses a merged field.

// File: rtl/llr_lowstage_mem.sv
module llr_lowstage_mem #(
  parameter int N       = 64,
  parameter int PE      = 8,
  parameter int Q       = 6,
  parameter int STAGE_W = $clog2($clog2(N) + 1),
  parameter int OFS_W   = $clog2(N / PE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [STAGE_W-1:0]  rd_stage,
  input  logic [OFS_W-1:0]    rd_ofs,
  input  logic                wr_en,
  input  logic [STAGE_W-1:0]  wr_stage,
  input  logic [OFS_W-1:0]    wr_ofs,
  input  logic [PE*Q-1:0]     wr_data,
  output logic [PE*Q-1:0]     rd_data,
  output logic                rd_valid
);
  localparam int LOG_N = $clog2(N);
  localparam int STHR  = $clog2(PE);
  localparam int NBIG  = N / PE - 1;
  localparam int W     = PE * Q;

  logic [W-1:0] big_q [NBIG];
  logic [W-1:0] pk_q  [2];
  logic         sel;

  function automatic logic big_ok(input int s, input int o);
    if (s < STHR || s >= LOG_N) return 1'b0;
    return o < (1 << (s - STHR));
  endfunction

  function automatic int big_idx(input int s, input int o);
    if (!big_ok(s, o)) return 0;
    return (1 << (s - STHR)) - 1 + o;
  endfunction

  wire rd_small = int'(rd_stage) < STHR;
  wire wr_small = int'(wr_stage) < STHR;
  wire rd_big   = big_ok(int'(rd_stage), int'(rd_ofs));
  wire wr_big   = big_ok(int'(wr_stage), int'(wr_ofs));
  wire [W-1:0] pk_cur = pk_q[sel];

  logic [W-1:0] pk_merged, rd_word;

  always_comb begin
    pk_merged = pk_cur;
    if (wr_small)
      for (int j = 0; j < PE; j++)
        if (j < (1 << int'(wr_stage)))
          pk_merged[((1 << int'(wr_stage)) - 1 + j)*Q +: Q] = wr_data[j*Q +: Q];
  end

  always_comb begin
    rd_word = '0;
    if (rd_small) begin
      for (int j = 0; j < PE; j++)
        if (j < (1 << int'(rd_stage)))
          rd_word[j*Q +: Q] = pk_cur[((1 << int'(rd_stage)) - 1 + j)*Q +: Q];
    end else if (rd_big) begin
      rd_word = big_q[big_idx(int'(rd_stage), int'(rd_ofs))];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      pk_q[0]  <= '0;
      pk_q[1]  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int k = 0; k < NBIG; k++) big_q[k] <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
      if (wr_en) begin
        if (wr_small) begin
          pk_q[!sel] <= pk_merged;
          sel        <= !sel;
        end else if (wr_big) begin
          big_q[big_idx(int'(wr_stage), int'(wr_ofs))] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/llr_lowstage_mem_chk.sv
module llr_lowstage_mem_chk #(
  parameter int N       = 64,
  parameter int PE      = 8,
  parameter int Q       = 6,
  parameter int STAGE_W = $clog2($clog2(N) + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [STAGE_W-1:0] rd_stage,
  input logic [PE*Q-1:0]    rd_data,
  input logic               rd_valid,
  input logic               wr_en,
  input logic [STAGE_W-1:0] wr_stage,
  input logic               sel
);
  localparam int LOG_N = $clog2(N);
  localparam int STHR  = $clog2(PE);

  wire pk_wr = wr_en && (int'(wr_stage) < STHR);

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_NO_VALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
  AST_SMALL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(rd_stage) < STHR) |=> ((rd_data >> (Q * (1 << int'($past(rd_stage))))) == '0)); // R4
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(rd_stage) >= LOG_N) |=> (rd_data == '0)); // R7
  AST_SWAP_ON_SMALL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pk_wr |=> (sel != $past(sel))); // R8
  AST_HOLD_COPY_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_wr |=> $stable(sel)); // R8
endmodule

bind llr_lowstage_mem llr_lowstage_mem_chk #(.N(N), .PE(PE), .Q(Q), .STAGE_W(STAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_stage(rd_stage), .rd_data(rd_data),
  .rd_valid(rd_valid), .wr_en(wr_en), .wr_stage(wr_stage), .sel(sel)
);

// File: tb/llr_lowstage_mem_tb.sv
module llr_lowstage_mem_tb_top;
  localparam int N = 64, PE = 8, Q = 6;
  localparam int LOG_N = $clog2(N), STHR = $clog2(PE), W = PE * Q;
  localparam int SW = $clog2(LOG_N + 1), OW = $clog2(N / PE);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [SW-1:0] rd_stage = '0, wr_stage = '0;
  logic [OW-1:0] rd_ofs = '0, wr_ofs = '0;
  logic [W-1:0]  wr_data = '0, rd_data;
  logic          rd_valid;

  always #2.5 clk = ~clk;

  llr_lowstage_mem #(.N(N), .PE(PE), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_stage(rd_stage), .rd_ofs(rd_ofs),
    .wr_en(wr_en), .wr_stage(wr_stage), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int total = 0, bad = 0;
  logic [Q-1:0] mdl [LOG_N][N];

  function automatic logic addr_ok(input int s, input int o);
    if (s >= LOG_N) return 1'b0;
    if (s < STHR) return 1'b1;
    return o * PE < (1 << s);
  endfunction

  function automatic logic [W-1:0] mread(input int s, input int o);
    logic [W-1:0] v = '0;
    if (!addr_ok(s, o)) return v;
    for (int i = 0; i < PE; i++)
      if (s < STHR) begin
        if (i < (1 << s)) v[i*Q +: Q] = mdl[s][i];
      end else v[i*Q +: Q] = mdl[s][o*PE + i];
    return v;
  endfunction

  task automatic mwrite(input int s, input int o, input logic [W-1:0] d);
    if (!addr_ok(s, o)) return;
    for (int i = 0; i < PE; i++)
      if (s < STHR) begin
        if (i < (1 << s)) mdl[s][i] = d[i*Q +: Q];
      end else mdl[s][o*PE + i] = d[i*Q +: Q];
  endtask

  task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic re, input int rs, input int ro, input logic we,
                      input int ws, input int wo, input logic [W-1:0] wd, input string tag);
    logic [W-1:0] exp_d;
    rd_en = re; rd_stage = SW'(rs); rd_ofs = OW'(ro);
    wr_en = we; wr_stage = SW'(ws); wr_ofs = OW'(wo); wr_data = wd;
    exp_d = mread(rs, ro);
    if (we) mwrite(ws, wo, wd);
    @(negedge clk);
    check(rd_valid == re, "R2 valid", W'(rd_valid), W'(re));
    if (re) check(rd_data == exp_d, tag, rd_data, exp_d);
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] v;
    for (int i = 0; i < PE; i++) v[i*Q +: Q] = Q'($urandom);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < LOG_N; s++) for (int i = 0; i < N; i++) mdl[s][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rd_valid == 1'b0, "R1 valid", W'(rd_valid), '0);
    check(rd_data == '0, "R1 data", rd_data, '0);
    for (int s = 0; s < LOG_N; s++)
      for (int o = 0; o < ((s < STHR) ? 1 : (1 << s) / PE); o++)
        step(1, s, o, 0, 0, 0, '0, "R1 zero after reset");

    step(0, 0, 0, 1, 5, 2, {PE{6'h15}} ^ 48'h0123_4567_89ab, "R3");
    step(1, 5, 2, 0, 0, 0, '0, "R3 readback");
    step(1, 5, 1, 1, 4, 1, rnd_word(), "R3 neighbour untouched");
    step(1, 4, 1, 1, 3, 0, rnd_word(), "R3 stage4");
    step(1, 3, 0, 0, 0, 0, '0, "R3 stage3");

    step(0, 0, 0, 1, 1, 3, rnd_word(), "R4");
    step(1, 1, 0, 0, 0, 0, '0, "R4 small read ofs ignored");
    step(0, 0, 0, 1, 0, 0, rnd_word(), "R8 back-to-back 0");
    step(0, 0, 0, 1, 2, 0, rnd_word(), "R8 back-to-back 2");
    step(0, 0, 0, 1, 1, 0, rnd_word(), "R8 back-to-back 1");
    step(1, 0, 0, 0, 0, 0, '0, "R5 stage0 kept");
    step(1, 2, 0, 0, 0, 0, '0, "R5 stage2 kept");
    step(1, 1, 0, 0, 0, 0, '0, "R8 stage1 latest");

    step(1, 5, 2, 1, 5, 2, rnd_word(), "R6 large same word old data");
    step(1, 5, 2, 0, 0, 0, '0, "R6 large new data next");
    step(1, 2, 0, 1, 2, 0, rnd_word(), "R6 shared same word old data");
    step(1, 2, 0, 0, 0, 0, '0, "R6 shared new data next");

    step(0, 0, 0, 1, 6, 0, rnd_word(), "R7 stage out of range");
    step(0, 0, 0, 1, 5, 5, rnd_word(), "R7 offset out of range");
    step(1, 7, 0, 0, 0, 0, '0, "R7 read stage 7");
    step(1, 3, 1, 0, 0, 0, '0, "R7 read offset beyond stage3");
    for (int s = 0; s < LOG_N; s++)
      for (int o = 0; o < ((s < STHR) ? 1 : (1 << s) / PE); o++)
        step(1, s, o, 0, 0, 0, '0, "R7 nothing overwritten");

    for (int n = 0; n < 3000; n++) begin
      int rs, ro, ws, wo;
      logic re, we;
      string tag;
      re = ($urandom_range(0, 3) != 0);
      we = ($urandom_range(0, 3) != 0);
      ws = $urandom_range(0, 7);
      wo = $urandom_range(0, 7);
      if (ws < LOG_N && $urandom_range(0, 3) != 0) wo = $urandom_range(0, 3) % (((ws < STHR) ? 1 : (1 << ws) / PE));
      if ($urandom_range(0, 2) == 0) begin rs = ws; ro = wo; end
      else begin
        rs = $urandom_range(0, 6);
        ro = (rs < LOG_N && rs >= STHR) ? $urandom_range(0, (1 << rs) / PE - 1) : $urandom_range(0, 7);
      end
      if (!addr_ok(rs, ro)) tag = "R7 random";
      else if (we && rs == ws && (rs < STHR || ro == wo)) tag = "R6 random";
      else if (rs < STHR) tag = "R4 random";
      else tag = "R3 random";
      step(re, rs, ro, we, ws, wo, rnd_word(), tag);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule